// File: doc/BRIEF.md
# Macrotick Expiry Timer (Absolute / Relative)

This block is a one-shot timer that runs on a cluster time base. Its time base has a macrotick-in-cycle position. The position returns to zero on a cycle-start strobe and advances by one on each macrotick enable pulse. One control bit picks how the timer reads its value register. In absolute mode the value is a position within the cycle, and the timer expires as the time base steps onto that position. In relative mode the value is a 32-bit macrotick count that is loaded at start and counted down.

Software sets the block up through a small word-wide write port. A control word holds the mode and the interrupt enable. Two value words form the 32-bit value, and a status word clears the expiry flag. The two modes treat a value rewrite during a run differently. An absolute run compares against the new offset from the next cycle on. A relative run holds the new value aside and moves it into the value register when the current countdown expires. Stopping the timer throws the held value away. The write port, start, stop, tick and cycle-start inputs are single-cycle control strobes with no handshake. No data stream crosses the block, so no valid/ready back-pressure is needed.

Top module: `mt_timer`

## Requirements
- R1: After reset, expired, irq and running are 0, the mode is absolute, the interrupt enable is 0 and the value is 0.
- R2: The time-base position becomes 0 in the cycle after cyc_start. Otherwise it advances by 1 (modulo 2^MT_W) in the cycle after mt_tick. cyc_start has priority over mt_tick.
- R3: Control word address 0 has bit 0 as the mode (0 absolute, 1 relative) and bit 1 as the interrupt enable. In absolute mode a running timer expires when the position advances onto value[MT_W-1:0].
- R4: In absolute mode, a value write during a run is compared against from the next cycle on.
- R5: A write to address 2 stages the high word. A write to address 1 sets the value to {staged high word, written low word} as one atomic update. In relative mode the count is loaded at start and decremented on each mt_tick. The tick that finds the count at 1 or 0 expires the timer.
- R6: In relative mode, a value write during a run is held and does not affect the current countdown. It becomes the value at expiry, and a later write wins over an earlier held one.
- R7: stop halts the timer in the next cycle, discards any held value, and has priority over start.
- R8: start loads the current value and sets running. A start during a run restarts the run and suppresses an expiry in that same cycle.
- R9: The expiry flag is sticky. Writing 1 to bit 0 of address 3 clears it, and a simultaneous expiry wins over the clear.
- R10: irq is high exactly when the expiry flag and the interrupt enable are both set.
- R11: A control write during a run updates the interrupt enable but leaves the mode unchanged.
- R12: The timer is one-shot: running drops in the cycle after an expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register word address (0 control, 1 value low, 2 value high, 3 status) |
| wr_data | input | DW | Write data word |
| start | input | 1 | Start (or restart) pulse |
| stop | input | 1 | Stop pulse |
| mt_tick | input | 1 | Macrotick enable pulse |
| cyc_start | input | 1 | Communication cycle start strobe |
| expired | output | 1 | Sticky expiry flag |
| irq | output | 1 | Interrupt request |
| running | output | 1 | Timer is armed or counting |

## Verification
On every cycle the assertions check these local behaviours. The expiry flag holds until it is cleared. A clear without a coinciding expiry takes effect. An expiry or a stop drops running. The mode stays stable while the timer runs. irq never rises without the flag, and an expiry never occurs while the timer is idle. Only the bench's cycle-accurate reference model can show the full behaviour. That covers the exact expiry cycle under sparse and dense tick patterns, the cycle-start wrap of the position, the immediate effect of an absolute rewrite, and the held relative value being promoted at expiry or discarded by stop. It also covers the atomic 32-bit pair, where the countdown crosses the 16-bit word boundary.

// File: rtl/mtt_pkg.sv
package mtt_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_VLO  = 2'd1;
  localparam logic [1:0] ADDR_VHI  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  typedef enum logic {
    MODE_ABS = 1'b0,
    MODE_REL = 1'b1
  } mtt_mode_e;
endpackage

// File: rtl/mtt_timebase.sv
module mtt_timebase #(
  parameter int MT_W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mt_tick,
  input  logic            cyc_start,
  output logic            adv,
  output logic [MT_W-1:0] pos_nxt
);
  logic [MT_W-1:0] pos_q;

  // cycle start returns to position zero and outranks a coinciding tick
  always_comb begin
    adv = cyc_start | mt_tick;
    if (cyc_start)    pos_nxt = '0;
    else if (mt_tick) pos_nxt = pos_q + MT_W'(1);
    else              pos_nxt = pos_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_nxt;
  end
endmodule

// File: rtl/mtt_regs.sv
module mtt_regs
  import mtt_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          running,
  input  logic          stop,
  input  logic          rel_expire,
  output mtt_mode_e     mode,
  output logic          irq_en,
  output logic [2*DW-1:0] value,
  output logic          flag_clr
);
  localparam int VW = 2 * DW;

  logic [DW-1:0] hi_stage_q;
  logic [VW-1:0] pend_q;
  logic          pend_vld_q;
  logic          commit;
  logic          defer;
  logic [VW-1:0] new_val;

  always_comb begin
    commit   = wr_en && (wr_addr == ADDR_VLO);
    new_val  = {hi_stage_q, wr_data};
    defer    = running && (mode == MODE_REL) && !stop && !rel_expire;
    flag_clr = wr_en && (wr_addr == ADDR_STAT) && wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= MODE_ABS;
      irq_en     <= 1'b0;
      hi_stage_q <= '0;
      value      <= '0;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
    end else begin
      if (wr_en && (wr_addr == ADDR_CTRL)) begin
        irq_en <= wr_data[1];
        if (!running) mode <= mtt_mode_e'(wr_data[0]);
      end
      if (wr_en && (wr_addr == ADDR_VHI)) hi_stage_q <= wr_data;

      if (commit && defer) begin
        pend_q     <= new_val;
        pend_vld_q <= 1'b1;
      end else if (commit) begin
        value      <= new_val;
        pend_vld_q <= 1'b0;
      end else if (rel_expire && pend_vld_q) begin
        value      <= pend_q;
        pend_vld_q <= 1'b0;
      end else if (stop) begin
        pend_vld_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mtt_core.sv
module mtt_core
  import mtt_pkg::*;
#(
  parameter int VW   = 32,
  parameter int MT_W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            stop,
  input  logic            mt_tick,
  input  logic            adv,
  input  logic [MT_W-1:0] pos_nxt,
  input  mtt_mode_e       mode,
  input  logic [VW-1:0]   value,
  input  logic            flag_clr,
  output logic            running,
  output logic            flag,
  output logic            expire,
  output logic            rel_expire
);
  logic [VW-1:0] cnt_q;
  logic          live;
  logic          abs_hit;

  always_comb begin
    live       = running && !stop && !start;
    abs_hit    = live && (mode == MODE_ABS) && adv && (pos_nxt == value[MT_W-1:0]);
    rel_expire = live && (mode == MODE_REL) && mt_tick && (cnt_q <= VW'(1));
    expire     = abs_hit | rel_expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt_q   <= '0;
      flag    <= 1'b0;
    end else begin
      if (stop)        running <= 1'b0;
      else if (start)  running <= 1'b1;
      else if (expire) running <= 1'b0;

      if (start && !stop)
        cnt_q <= value;
      else if (running && !stop && mt_tick && (mode == MODE_REL))
        cnt_q <= cnt_q - VW'(1);

      if (expire)        flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/mt_timer.sv
module mt_timer
  import mtt_pkg::*;
#(
  parameter int DW   = 16,
  parameter int MT_W = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          start,
  input  logic          stop,
  input  logic          mt_tick,
  input  logic          cyc_start,
  output logic          expired,
  output logic          irq,
  output logic          running
);
  localparam int VW = 2 * DW;

  logic            adv;
  logic [MT_W-1:0] pos_nxt;
  mtt_mode_e       mode_w;
  logic            irq_en_w;
  logic [VW-1:0]   value_w;
  logic            flag_clr_w;
  logic            expire_w;
  logic            rel_expire_w;

  mtt_timebase #(.MT_W(MT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .mt_tick(mt_tick), .cyc_start(cyc_start),
    .adv(adv), .pos_nxt(pos_nxt)
  );

  mtt_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .running(running), .stop(stop), .rel_expire(rel_expire_w),
    .mode(mode_w), .irq_en(irq_en_w), .value(value_w), .flag_clr(flag_clr_w)
  );

  mtt_core #(.VW(VW), .MT_W(MT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .mt_tick(mt_tick),
    .adv(adv), .pos_nxt(pos_nxt), .mode(mode_w), .value(value_w),
    .flag_clr(flag_clr_w), .running(running), .flag(expired),
    .expire(expire_w), .rel_expire(rel_expire_w)
  );

  assign irq = expired & irq_en_w;
endmodule

// File: rtl/mt_timer_chk.sv
module mt_timer_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          start,
  input logic          stop,
  input logic          expired,
  input logic          irq,
  input logic          running,
  input logic          mode,
  input logic          expire
);
  logic clr_wr;
  assign clr_wr = wr_en && (wr_addr == 2'd3) && wr_data[0];

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !clr_wr) |=> expired);

  a_r9_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !expire) |=> !expired);

  a_r9_expire_sets: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> expired);

  a_r12_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !start) |=> !running);

  a_r7_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !running);

  a_r11_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> $stable(mode));

  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> expired);

  a_r8_expire_only_running: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> running);
endmodule

bind mt_timer mt_timer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .start(start), .stop(stop), .expired(expired), .irq(irq), .running(running),
  .mode(mode_w), .expire(expire_w)
);

// File: tb/mt_timer_tb.sv
`timescale 1ns/1ps
module mt_timer_tb;
  localparam int DW   = 16;
  localparam int MT_W = 14;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          wr_en = 0;
  logic [1:0]    wr_addr = 0;
  logic [DW-1:0] wr_data = 0;
  logic          start = 0, stop = 0, mt_tick = 0, cyc_start = 0;
  logic          expired, irq, running;

  always #2.5 clk = ~clk;

  mt_timer #(.DW(DW), .MT_W(MT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .stop(stop), .mt_tick(mt_tick), .cyc_start(cyc_start),
    .expired(expired), .irq(irq), .running(running)
  );

  // behavioural reference model
  int  m_pos, m_mode, m_ie, m_run, m_flag, m_pv;
  longint m_cnt, m_val, m_hi, m_pend;
  int  n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 0; m_mode = 0; m_ie = 0; m_run = 0; m_flag = 0; m_pv = 0;
      m_cnt = 0; m_val = 0; m_hi = 0; m_pend = 0;
    end else begin
      int npos, live, ex, rex, commit, defer, clr, nrun;
      longint nval, ncnt;
      npos = cyc_start ? 0 : (mt_tick ? (m_pos + 1) % (1 << MT_W) : m_pos);
      live = m_run && !stop && !start;
      rex  = live && m_mode == 1 && mt_tick && m_cnt <= 1;
      ex   = rex || (live && m_mode == 0 && (cyc_start || mt_tick) &&
                     npos == (m_val % (1 << MT_W)));
      commit = wr_en && wr_addr == 1;
      nval = (m_hi << 16) | longint'(wr_data);
      defer = m_run && m_mode == 1 && !stop && !rex;
      clr = wr_en && wr_addr == 3 && wr_data[0];
      nrun = stop ? 0 : (start ? 1 : (ex ? 0 : m_run));
      ncnt = m_cnt;
      if (start && !stop) ncnt = m_val;
      else if (m_run && !stop && mt_tick && m_mode == 1) ncnt = (m_cnt - 1) & 64'hFFFF_FFFF;
      if (commit && defer) begin m_pend = nval; m_pv = 1; end
      else if (commit) begin m_val = nval; m_pv = 0; end
      else if (rex && m_pv) begin m_val = m_pend; m_pv = 0; end
      else if (stop) m_pv = 0;
      if (wr_en && wr_addr == 0) begin
        m_ie = wr_data[1];
        if (!m_run) m_mode = wr_data[0];
      end
      if (wr_en && wr_addr == 2) m_hi = wr_data;
      if (ex) m_flag = 1; else if (clr) m_flag = 0;
      m_run = nrun; m_cnt = ncnt; m_pos = npos;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("expired", expired, m_flag);
    chk("irq", irq, m_flag & m_ie);
    chk("running", running, m_run);
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 0; start = 0; stop = 0; mt_tick = 0; cyc_start = 0;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d; start = 0; stop = 0; mt_tick = 0; cyc_start = 0;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1; @(negedge clk); start = 0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop = 1; @(negedge clk); stop = 0;
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); mt_tick = 1;
      @(negedge clk); mt_tick = 0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
  endtask

  task automatic cyc();
    @(negedge clk); cyc_start = 1; @(negedge clk); cyc_start = 0;
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1";
    idle(1);
    chk("reset expired", expired, 0);
    chk("reset running", running, 0);
    chk("reset irq", irq, 0);

    cur_req = "R2 R3";
    wr(0, 16'h0002); wr(1, 5); cyc(); pulse_start();
    ticks(8, 1); cyc(); ticks(6, 0);
    wr(3, 1);

    cur_req = "R4";
    cyc(); wr(1, 20); pulse_start(); ticks(3, 0);
    wr(1, 8); ticks(7, 2);
    wr(3, 1);

    cur_req = "R2";
    wr(1, 3); pulse_start(); ticks(2, 0);
    @(negedge clk); cyc_start = 1; mt_tick = 1; @(negedge clk); cyc_start = 0; mt_tick = 0;
    ticks(4, 0); wr(3, 1);

    cur_req = "R5";
    wr(0, 16'h0003); wr(2, 0); wr(1, 6); pulse_start(); ticks(7, 3);
    wr(3, 1);
    wr(1, 0); pulse_start(); ticks(2, 0); wr(3, 1);

    cur_req = "R6";
    wr(1, 10); pulse_start(); ticks(2, 0); wr(1, 4); wr(1, 3); ticks(9, 0);
    pulse_start(); ticks(4, 1); wr(3, 1);

    cur_req = "R7";
    wr(1, 10); pulse_start(); ticks(2, 0); wr(1, 4); pulse_stop(); ticks(2, 0);
    pulse_start(); ticks(11, 0);
    @(negedge clk); start = 1; stop = 1; @(negedge clk); start = 0; stop = 0;
    ticks(2, 0); wr(3, 1);

    cur_req = "R8";
    wr(1, 4); pulse_start(); ticks(3, 0);
    @(negedge clk); start = 1; mt_tick = 1; @(negedge clk); start = 0; mt_tick = 0;
    ticks(5, 0); wr(3, 1);

    cur_req = "R11";
    wr(1, 6); pulse_start(); ticks(2, 0); wr(0, 16'h0000); ticks(5, 0);
    wr(0, 16'h0002); pulse_start(); ticks(1, 0); pulse_stop();

    cur_req = "R9 R10";
    wr(0, 16'h0001); wr(1, 2); pulse_start(); mt_tick = 0; ticks(1, 0);
    @(negedge clk); mt_tick = 1; wr_en = 1; wr_addr = 3; wr_data = 1;
    @(negedge clk); mt_tick = 0; wr_en = 0;
    idle(3); wr(0, 16'h0003); idle(2); wr(0, 16'h0001); idle(1);
    wr(3, 0); idle(1); wr(3, 1); idle(2);

    cur_req = "R12 R5";
    wr(2, 1); wr(1, 2); pulse_start();
    for (int i = 0; i < 65540; i++) begin @(negedge clk); mt_tick = 1; end
    @(negedge clk); mt_tick = 0; idle(2); wr(3, 1);

    cur_req = "R2 R3 R6 R7 R9";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      mt_tick   = ($urandom % 3) != 0;
      cyc_start = ($urandom % 40) == 0;
      start     = ($urandom % 30) == 0;
      stop      = ($urandom % 60) == 0;
      wr_en     = ($urandom % 8) == 0;
      wr_addr   = 2'($urandom % 4);
      wr_data   = (wr_addr == 2) ? 16'h0 : 16'($urandom % 24);
    end
    idle(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule